// File: doc/BRIEF.md
# Fixed-plus-switchable ROM bank mapper

This block maps a 32 KiB processor ROM space onto a larger cartridge ROM. The space is split in two. The lower 16 KiB window, with address bit 14 low, always reaches ROM bank 0. The upper 16 KiB window, with address bit 14 high, reaches whichever bank software last selected. A single write-only bank register holds that selection. It is loaded from the low data-bus bits by any write strobe that lands in the lower half of the processor map (address bit 15 low). Software that writes a conventional bank port such as $2000 therefore behaves the same as on a fuller mapper.

The write strobe is sampled on the system clock, and a write takes effect when the strobe returns high. The ROM itself never drives the bus during a register write. The block outputs a full ROM address made of the gated bank bits above the 14 in-window offset bits. This address is registered, so it follows the processor address with one clock of latency. A synchronous reset selects bank 1, so the two windows differ from the first access onward. With default parameters the block addresses 16 banks, which is 256 KiB.

Top module: `minibank_mapper`

## Requirements
- R1: While `rst` is high, `rom_addr_o` reads 0. After reset the selected bank is 1, so a read at $4000 gives ROM address 0x04000.
- R2: When address bit 14 is low, the bank field `rom_addr_o[17:14]` is 0, whatever bank is selected.
- R3: When address bit 14 is high, `rom_addr_o[17:14]` equals the selected bank, including bank 0 and bank 15.
- R4: A write strobe with address bit 15 low loads `cpu_data_i[3:0]` into the bank register. This holds at any address in $0000-$7FFF, for example $0000, $2000, $3000 and $7FFF.
- R5: `cpu_data_i[7:4]` has no effect on the selected bank.
- R6: A write strobe with address bit 15 high leaves the selected bank unchanged.
- R7: `rom_addr_o` is registered. It reflects the processor address and bank that were present at the previous rising clock edge.
- R8: The bank changes only on the clock edge that sees `cpu_wr_n_i` high after it was low. While the strobe is held low, the old bank stays in use.
- R9: `rom_addr_o[13:0]` equals the processor address bits [13:0]. The bank field follows address bit 14 alone, even when address bit 15 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | 16 | Processor address bus |
| cpu_wr_n_i | input | 1 | Active-low write strobe |
| cpu_data_i | input | 8 | Processor data bus |
| rom_addr_o | output | 18 | Registered ROM address: bank field above 14 offset bits |

## Verification
The bank register is the only state in the block that software can change. A wrong value in it can be seen only through an upper-window read, which shows it in the next registered `rom_addr_o`, one clock after the address is presented. A lower-window read cannot reveal it. For that reason, every write in the stimulus is followed by a read at an address with bit 14 set. A wrong strobe-edge state shows up as a bank that changes while the strobe is still low, or that misses a completed write. The bench samples during a held-low strobe to catch this.

// File: rtl/minibank_pkg.sv
package minibank_pkg;
  typedef enum logic {
    WIN_FIXED  = 1'b0,
    WIN_SWITCH = 1'b1
  } window_e;

  function automatic window_e window_of(input logic sel_bit);
    return sel_bit ? WIN_SWITCH : WIN_FIXED;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic wr_n_i,
  output logic fire_o
);
  logic wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n_i;
  end

  // fires once, on the cycle the strobe returns high
  assign fire_o = !wr_n_q && wr_n_i;
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
  parameter int BANK_W     = 4,
  parameter int RESET_BANK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic              bus_hi_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [BANK_W-1:0] BANK_INIT = BANK_W'(RESET_BANK);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst)                     bank_q <= BANK_INIT;
    else if (fire_i && !bus_hi_i) bank_q <= data_i;
  end

  assign bank_o = bank_q;

  // R4 / R5: only the low data bits land in the register
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (fire_i && !bus_hi_i) |=> (bank_q == $past(data_i)));

  assert_upper_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (fire_i && bus_hi_i) |=> $stable(bank_q));

  assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> $stable(bank_q));
endmodule

// File: rtl/rom_addr_mux.sv
module rom_addr_mux
  import minibank_pkg::*;
#(
  parameter int BANK_W   = 4,
  parameter int OFFSET_W = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       win_bit_i,
  input  logic [OFFSET_W-1:0]        offset_i,
  input  logic [BANK_W-1:0]          bank_i,
  output logic [BANK_W+OFFSET_W-1:0] rom_addr_o
);
  localparam int ROM_AW = BANK_W + OFFSET_W;

  window_e           win;
  logic [BANK_W-1:0] bank_gated;
  logic [ROM_AW-1:0] rom_addr_q;

  assign win = window_of(win_bit_i);

  for (genvar b = 0; b < BANK_W; b++) begin : g_gate
    assign bank_gated[b] = bank_i[b] && (win == WIN_SWITCH);
  end

  always_ff @(posedge clk) begin
    if (rst) rom_addr_q <= '0;
    else     rom_addr_q <= {bank_gated, offset_i};
  end

  assign rom_addr_o = rom_addr_q;

  assert_fixed_window_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(win_bit_i) |-> (rom_addr_q[ROM_AW-1:OFFSET_W] == '0));

  assert_switch_window_bank_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(win_bit_i)) |-> (rom_addr_q[ROM_AW-1:OFFSET_W] == $past(bank_i)));

  assert_offset_through_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rom_addr_q[OFFSET_W-1:0] == $past(offset_i)));
endmodule

// File: rtl/minibank_mapper.sv
module minibank_mapper #(
  parameter int BANK_W     = 4,
  parameter int OFFSET_W   = 14,
  parameter int DATA_W     = 8,
  parameter int RESET_BANK = 1,
  localparam int ADDR_W    = OFFSET_W + 2,
  localparam int ROM_AW    = BANK_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_n_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int WIN_BIT = OFFSET_W;
  localparam int BUS_BIT = OFFSET_W + 1;

  logic              fire;
  logic [BANK_W-1:0] bank;
  logic              unused_data_hi;

  // R5: upper data bits are not wired into the register
  assign unused_data_hi = ^cpu_data_i[DATA_W-1:BANK_W];

  strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .wr_n_i (cpu_wr_n_i),
    .fire_o (fire)
  );

  bank_latch #(
    .BANK_W     (BANK_W),
    .RESET_BANK (RESET_BANK)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (fire),
    .bus_hi_i (cpu_addr_i[BUS_BIT]),
    .data_i   (cpu_data_i[BANK_W-1:0]),
    .bank_o   (bank)
  );

  rom_addr_mux #(
    .BANK_W   (BANK_W),
    .OFFSET_W (OFFSET_W)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .win_bit_i  (cpu_addr_i[WIN_BIT]),
    .offset_i   (cpu_addr_i[OFFSET_W-1:0]),
    .bank_i     (bank),
    .rom_addr_o (rom_addr_o)
  );
endmodule

// File: tb/tb_minibank_mapper.sv
module tb_minibank_mapper;
  typedef struct packed {
    logic        is_wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [17:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h4000, 8'h00, 18'h04000, 4'd1}, // R1 reset bank
    '{1'b0, 16'h1234, 8'h00, 18'h01234, 4'd2}, // R2
    '{1'b1, 16'h2000, 8'h05, 18'h00000, 4'd4}, // R4 write at $2000
    '{1'b0, 16'h4ABC, 8'h00, 18'h14ABC, 4'd3}, // R3
    '{1'b0, 16'h3FFF, 8'h00, 18'h03FFF, 4'd2}, // R2
    '{1'b1, 16'h0000, 8'hF3, 18'h00000, 4'd5}, // R5 high nibble junk
    '{1'b0, 16'h7FFF, 8'h00, 18'h0FFFF, 4'd5}, // R5
    '{1'b1, 16'hA000, 8'h09, 18'h00000, 4'd6}, // R6 ignored
    '{1'b0, 16'h4001, 8'h00, 18'h0C001, 4'd6}, // R6
    '{1'b1, 16'h7FFF, 8'h0F, 18'h00000, 4'd4}, // R4 write at $7FFF
    '{1'b0, 16'h6000, 8'h00, 18'h3E000, 4'd3}, // R3 bank 15
    '{1'b1, 16'h8000, 8'h00, 18'h00000, 4'd6}, // R6 ignored
    '{1'b0, 16'h4000, 8'h00, 18'h3C000, 4'd6}, // R6
    '{1'b1, 16'h3000, 8'h0A, 18'h00000, 4'd4}, // R4 write at $3000
    '{1'b0, 16'h5555, 8'h00, 18'h29555, 4'd3}, // R3
    '{1'b0, 16'hC123, 8'h00, 18'h28123, 4'd9}, // R9 A15 high, A14 high
    '{1'b0, 16'hA123, 8'h00, 18'h02123, 4'd9}  // R9 A15 high, A14 low
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr_n = 1'b1;
  logic [7:0]  cpu_data = '0;
  logic [17:0] rom_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  minibank_mapper dut (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr_i (cpu_addr),
    .cpu_wr_n_i (cpu_wr_n),
    .cpu_data_i (cpu_data),
    .rom_addr_o (rom_addr)
  );

  task automatic check(input string tag, input logic [17:0] exp);
    checks++;
    if (rom_addr !== exp) begin
      errors++;
      $display("FAIL %s: rom_addr=%05h expected=%05h", tag, rom_addr, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr_n = 1'b0;
    @(negedge clk);
    cpu_wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 output during reset", 18'h00000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) begin
        do_write(VEC[i].addr, VEC[i].data);
      end else begin
        do_read(VEC[i].addr);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
      end
    end

    // R7: output lags the address by one clock (bank is 10 here)
    do_read(16'h4000);
    cpu_addr = 16'h0010;
    #1;
    check("R7 old value before edge", 18'h28000);
    @(negedge clk);
    check("R7 new value after edge", 18'h00010);

    // R8: strobe held low keeps the old bank in use
    cpu_addr = 16'h6000; cpu_data = 8'h02; cpu_wr_n = 1'b0;
    @(negedge clk);
    check("R8 strobe low cycle 1", 18'h2A000);
    @(negedge clk);
    check("R8 strobe low cycle 2", 18'h2A000);
    cpu_wr_n = 1'b1;
    @(negedge clk);
    do_read(16'h6000);
    check("R8 bank after release", 18'h0A000);

    // R1: reset in mid-run returns to bank 1
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 output in mid-run reset", 18'h00000);
    rst = 1'b0;
    do_read(16'h4000);
    check("R1 bank after mid-run reset", 18'h04000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule